// File: doc/BRIEF.md
# Edge-Selectable Interrupt Control Register Bank

This block holds one control byte per interrupt source on a byte-wide register port. Each byte carries a 3-bit priority level and a pending-request flag. External-pin sources also carry an edge polarity select.

External-pin sources pass through a synchronizer and an edge detector. Depending on their settings they raise their flag on a falling edge, a rising edge or both edges. Internal sources are synchronous strobes from on-chip peripherals; they raise their flag in any cycle their line is high.

All pending sources with a non-zero level compete in an arbiter. The winner is offered to the CPU only when its level is strictly above the processor's current priority threshold. The CPU answers with a one-cycle acknowledge, which retires the granted source's flag. Software clears a flag by writing 0 to it; writing 1 never sets it.

Top module: `irq_ctrl_bank`

## Requirements
- R1: After reset every control byte, the both-edge mode byte and `rdata_o` read 0, and `irq_o` is 0.
- R2: Bits [2:0] of control byte i (address i) hold its level; level 0 disables the source, so a pending source at level 0 is never granted.
- R3: Bit 3 of a control byte is the request flag (1 = pending). A write with bit 3 = 0 clears it. A write with bit 3 = 1 leaves it unchanged.
- R4: For external sources (index below NUM_EXT), bit 4 selects the edge: 0 = falling, 1 = rising; the other edge is ignored. For internal sources, bit 4 reads 0.
- R5: Bits [7:5] of every control byte read 0 whatever was written.
- R6: Bit i of the mode byte at address NUM_SRC turns on both-edge detection for external source i. Either edge then sets the flag, whatever bit 4 holds.
- R7: If a detected edge coincides with a software write of 0 to the flag, the flag stays set.
- R8: `irq_o` is 1 only when the winning level is strictly greater than `cpu_ipl_i`.
- R9: The winner is the pending, enabled source with the highest level; among equal levels the lowest index wins. Its index and level appear on `irq_id_o` and `irq_lvl_o`.
- R10: A cycle with `ack_i` = 1 while `irq_o` = 1 clears the flag of source `irq_id_o`. The next winner is offered two cycles after the acknowledge.
- R11: An external pin change sets the flag at the third rising clock edge after it. `irq_o` follows one clock later. A read returns the register state at the clock edge after `addr_i` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register address (0..NUM_SRC-1 control bytes, NUM_SRC mode byte) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data for `addr_i` |
| src_i | input | NUM_SRC | Source lines; external pins first, then internal strobes |
| cpu_ipl_i | input | 3 | Processor priority threshold |
| ack_i | input | 1 | Acknowledge of the granted source |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | ID_W | Index of the granted source |
| irq_lvl_o | output | 3 | Level of the granted source |

## Verification
The hardest case to reach is a pin edge that lands on the same clock edge as a software write clearing the flag. The stimulus first sets the flag with one pin edge. It then drives the opposite edge in both-edge mode and counts the synchronizer stages. The clearing write is issued so that it commits on the exact edge where the detector fires. The tie-break and the strict threshold compare are reached by loading two sources of equal level. An acknowledge then sweeps the pending set down while the threshold is stepped.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LVL_W   = 3;
  localparam int BIT_REQ = 3;
  localparam int BIT_POL = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/icr_edge_det.sv
module icr_edge_det #(
  parameter bit EXTERNAL    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic pol_i,
  input  logic both_i,
  output logic evt_o
);
  generate
    if (EXTERNAL) begin : g_pin
      logic [SYNC_STAGES-1:0] sync_q;
      logic                   prev_q;
      logic                   rise, fall;
      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q <= '0;
          prev_q <= 1'b0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], src_i};
          prev_q <= sync_q[SYNC_STAGES-1];
        end
      end
      assign rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
      assign fall  = ~sync_q[SYNC_STAGES-1] & prev_q;
      assign evt_o = both_i ? (rise | fall) : (pol_i ? rise : fall);
    end else begin : g_strobe
      logic unused_cfg;
      assign unused_cfg = ^{clk, rst, pol_i, both_i};
      assign evt_o = src_i;
    end
  endgenerate
endmodule

// File: rtl/icr_arbiter.sv
module icr_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  input  lvl_t                     ipl_i,
  output logic                     irq_o,
  output logic [ID_W-1:0]          id_o,
  output lvl_t                     lvl_o
);
  lvl_t            best_lvl;
  logic [ID_W-1:0] best_id;

  // Scan from the top index down so that ">=" lets the lower index win a tie.
  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (lvl_i[i*LVL_W +: LVL_W] != '0) &&
          (lvl_i[i*LVL_W +: LVL_W] >= best_lvl)) begin
        best_lvl = lvl_i[i*LVL_W +: LVL_W];
        best_id  = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      id_o  <= '0;
      lvl_o <= '0;
    end else begin
      irq_o <= (best_lvl != '0) && (best_lvl > ipl_i);
      id_o  <= best_id;
      lvl_o <= best_lvl;
    end
  end

  p_level_zero_never_r2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (lvl_o != '0));
  p_above_ipl_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (lvl_o > $past(ipl_i)));
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
  import irq_ctrl_pkg::*;
#(
  parameter  int NUM_SRC     = 8,
  parameter  int NUM_EXT     = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(NUM_SRC + 1),
  localparam int ID_W        = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [2:0]        cpu_ipl_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic [2:0]        irq_lvl_o
);
  logic [NUM_SRC*LVL_W-1:0] lvl_q;
  logic [NUM_SRC-1:0]       req_q;
  logic [NUM_SRC-1:0]       evt;
  logic [NUM_EXT-1:0]       pol_q;
  logic [NUM_EXT-1:0]       both_q;
  logic [7:0]               rd_word [NUM_SRC+1];

  // Both-edge mode byte
  always_ff @(posedge clk) begin
    if (rst) both_q <= '0;
    else if (wr_i && addr_i == ADDR_W'(NUM_SRC)) both_q <= wdata_i[NUM_EXT-1:0];
  end
  assign rd_word[NUM_SRC] = {{(8-NUM_EXT){1'b0}}, both_q};

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic sel;
      assign sel = wr_i && (addr_i == ADDR_W'(g));

      always_ff @(posedge clk) begin
        if (rst) lvl_q[g*LVL_W +: LVL_W] <= '0;
        else if (sel) lvl_q[g*LVL_W +: LVL_W] <= wdata_i[LVL_W-1:0];
      end

      // Set by an edge beats any clear; software can only clear.
      always_ff @(posedge clk) begin
        if (rst)                                            req_q[g] <= 1'b0;
        else if (evt[g])                                    req_q[g] <= 1'b1;
        else if (ack_i && irq_o && irq_id_o == ID_W'(g))    req_q[g] <= 1'b0;
        else if (sel && !wdata_i[BIT_REQ])                  req_q[g] <= 1'b0;
      end

      if (g < NUM_EXT) begin : g_ext
        always_ff @(posedge clk) begin
          if (rst) pol_q[g] <= 1'b0;
          else if (sel) pol_q[g] <= wdata_i[BIT_POL];
        end
        icr_edge_det #(.EXTERNAL(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_det (
          .clk(clk), .rst(rst), .src_i(src_i[g]),
          .pol_i(pol_q[g]), .both_i(both_q[g]), .evt_o(evt[g]));
        assign rd_word[g] = {3'b000, pol_q[g], req_q[g], lvl_q[g*LVL_W +: LVL_W]};
      end else begin : g_int
        icr_edge_det #(.EXTERNAL(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_det (
          .clk(clk), .rst(rst), .src_i(src_i[g]),
          .pol_i(1'b0), .both_i(1'b0), .evt_o(evt[g]));
        assign rd_word[g] = {4'b0000, req_q[g], lvl_q[g*LVL_W +: LVL_W]};
      end

      p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
        evt[g] |=> req_q[g]);
      p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (sel && wdata_i[BIT_REQ] && !req_q[g] && !evt[g]) |=> !req_q[g]);
      p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o && irq_id_o == ID_W'(g) && !evt[g]) |=> !req_q[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (int'(addr_i) <= NUM_SRC) rdata_o <= rd_word[addr_i];
    else rdata_o <= '0;
  end

  icr_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst(rst), .req_i(req_q), .lvl_i(lvl_q), .ipl_i(cpu_ipl_i),
    .irq_o(irq_o), .id_o(irq_id_o), .lvl_o(irq_lvl_o));
endmodule

// File: tb/tb_irq_ctrl_bank.sv
module tb_irq_ctrl_bank;
  localparam int NS = 8;
  localparam int NE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NS-1:0] src = '0;
  logic [2:0] ipl = '0;
  logic       ack = 1'b0;
  logic       irq;
  logic [2:0] irq_id;
  logic [2:0] irq_lvl;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t q[$];
  logic rd_pend = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_bank #(.NUM_SRC(NS), .NUM_EXT(NE)) dut (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .cpu_ipl_i(ipl), .ack_i(ack),
    .irq_o(irq), .irq_id_o(irq_id), .irq_lvl_o(irq_lvl));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares each registered read against the queued expectation.
  always @(posedge clk) begin
    if (rd_pend) begin
      rd_item_t it;
      it = q.pop_front();
      #2;
      chk(rdata, it.exp, it.tag);
    end
  end

  task automatic wr_reg(input int a, input logic [7:0] d);
    @(negedge clk); addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk); addr = 4'(a); it.exp = e; it.tag = tag; q.push_back(it); rd_pend = 1'b1;
    @(negedge clk); rd_pend = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e_irq, input logic [2:0] e_id,
                         input logic [2:0] e_lvl, input string tag);
    chk({7'b0, irq}, {7'b0, e_irq}, {tag, " irq"});
    if (e_irq) begin
      chk({5'b0, irq_id}, {5'b0, e_id}, {tag, " id"});
      chk({5'b0, irq_lvl}, {5'b0, e_lvl}, {tag, " lvl"});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, 3'd0, 3'd0, "R1");
    for (int i = 0; i <= NS; i++) rd_reg(i, 8'h00, "R1 reset byte");

    // R3 write one ignored, R4 pol stored, R5 upper bits zero
    wr_reg(0, 8'hFF);
    rd_reg(0, 8'h17, "R3 R5 external write FF");
    wr_reg(4, 8'hFF);
    rd_reg(4, 8'h07, "R4 R5 internal write FF");

    // R4 rising select, R11 latency
    wr_reg(0, 8'h13);
    @(negedge clk); src[0] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk_irq(1'b0, 3'd0, 3'd0, "R11 irq one clock after flag");
    @(negedge clk);
    chk_irq(1'b1, 3'd0, 3'd3, "R11 R4 rising edge grant");
    rd_reg(0, 8'h1B, "R4 flag set on rising edge");

    // R10 acknowledge clears
    do_ack();
    chk_irq(1'b0, 3'd0, 3'd0, "R10 after ack");
    rd_reg(0, 8'h13, "R10 flag cleared by ack");

    // R4 falling edge ignored while rising selected
    @(negedge clk); src[0] = 1'b0;
    idle(6);
    chk_irq(1'b0, 3'd0, 3'd0, "R4 falling ignored");
    rd_reg(0, 8'h13, "R4 falling ignored");

    // R4 falling select
    wr_reg(0, 8'h03);
    @(negedge clk); src[0] = 1'b1;
    idle(6);
    rd_reg(0, 8'h03, "R4 rising ignored with falling select");
    @(negedge clk); src[0] = 1'b0;
    idle(6);
    rd_reg(0, 8'h0B, "R4 falling detected");
    wr_reg(0, 8'h03);
    rd_reg(0, 8'h03, "R3 write zero clears");

    // R6 both-edge mode
    wr_reg(NS, 8'h01);
    rd_reg(NS, 8'h01, "R6 mode byte readback");
    @(negedge clk); src[0] = 1'b1;
    idle(6);
    rd_reg(0, 8'h0B, "R6 rising in both mode");
    wr_reg(0, 8'h03);
    @(negedge clk); src[0] = 1'b0;
    idle(6);
    rd_reg(0, 8'h0B, "R6 falling in both mode");
    wr_reg(0, 8'h03);

    // R7 edge coincides with clearing write
    @(negedge clk); src[0] = 1'b1;
    idle(6);
    @(negedge clk); src[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = 4'd0; wdata = 8'h03; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_reg(0, 8'h0B, "R7 edge wins over write zero");
    wr_reg(0, 8'h03);
    rd_reg(0, 8'h03, "R7 later clear works");

    // R9 tie-break, R8 threshold, R2 level zero
    wr_reg(1, 8'h15);
    wr_reg(2, 8'h10);
    wr_reg(4, 8'h05);
    wr_reg(5, 8'h02);
    @(negedge clk); src[1] = 1'b1; src[2] = 1'b1; src[5:4] = 2'b11;
    @(negedge clk); src[5:4] = 2'b00;
    idle(6);
    chk_irq(1'b1, 3'd1, 3'd5, "R9 tie lowest index");
    @(negedge clk); ipl = 3'd5;
    @(negedge clk);
    chk_irq(1'b0, 3'd0, 3'd0, "R8 equal level blocked");
    @(negedge clk); ipl = 3'd4;
    @(negedge clk);
    chk_irq(1'b1, 3'd1, 3'd5, "R8 above threshold");
    do_ack();
    chk_irq(1'b1, 3'd4, 3'd5, "R10 R9 next winner");
    do_ack();
    chk_irq(1'b0, 3'd0, 3'd0, "R8 level 2 under threshold 4");
    @(negedge clk); ipl = 3'd1;
    @(negedge clk);
    chk_irq(1'b1, 3'd5, 3'd2, "R8 R9 lower level granted");
    @(negedge clk); ipl = 3'd0;
    do_ack();
    chk_irq(1'b0, 3'd0, 3'd0, "R2 level zero never granted");
    rd_reg(2, 8'h18, "R2 level zero source still pending");

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule